// File: doc/BRIEF.md
# Display PLL Power and Enable Sequencer

This block takes one display PLL through its bring-up and shut-down steps in a fixed order. A single-cycle enable command starts the bring-up. The block raises the PLL power request and waits for the power-state status. It then writes configuration word 0 to the PLL, reads it back, and does the same for configuration word 1 when word 0 selects HDMI mode. Last, it raises the PLL enable and waits for lock. A disable command runs the shut-down: it drops the enable, waits for lock to go away, drops the power request, and waits for the power-state status to clear.

Each status wait is bounded by a timeout counted in clock cycles. The count comes from the clock frequency and the wait time, both parameters; the defaults give 5 ms. A wait that runs out sets its own sticky error flag, and the sequence carries on to the next step. A state query returns whether the PLL is enabled, together with the configuration words captured during the read-backs. Word 1 is only returned when HDMI mode is selected, so the query never reports a stale value.

Top module: `dpll_seq`

## Requirements
- R1: After an accepted enable, the power request rises first. Once the power-state status is seen, word 0 is written, then word 1 if it is to be written, then the PLL enable rises. Busy clears in the cycle after lock is seen. The PLL enable is never high while the power request is low.
- R2: Configuration word 1 is written only when bit HDMI_BIT (default bit 0) of the latched word 0 is 1. In every other case no write with `cfg_sel`=1 occurs.
- R3: Every write strobe `cfg_wr` is followed in the next cycle by a read strobe `cfg_rd` with the same `cfg_sel`. `cfg_rdata` is captured at the end of that read cycle, and the sequence then moves on.
- R4: After an accepted disable, the PLL enable falls first. The power request falls in the cycle after lock is seen low, and busy clears in the cycle after the power-state status is seen low.
- R5: A wait whose status does not arrive ends after exactly TMO_CYC cycles in the wait, and the sequence continues. The flag that is set depends on the wait: power-up sets `err[0]`, lock sets `err[1]`, unlock sets `err[2]` and power-down sets `err[3]`.
- R6: Error flags are sticky. Once set, a flag stays set until reset.
- R7: A query pulse gives `qry_valid` one cycle later. With it comes `qry_on` equal to the PLL enable, and `qry_cfg0` holding the captured word 0, or zero when the PLL is disabled. `qry_cfg1` holds the captured word 1 only when the PLL is enabled and captured word 0 has HDMI mode set; otherwise it is zero.
- R8: Busy is high from the cycle after a command is accepted until the sequence ends. Commands that arrive while busy are ignored. When enable and disable arrive together in idle, enable wins.
- R9: After reset, all strobes, the power request, the PLL enable, busy, all error flags and `qry_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enable command pulse |
| cmd_dis | input | 1 | Disable command pulse |
| cfg_word0_in | input | CFG_W | Configuration word 0, latched when an enable is accepted |
| cfg_word1_in | input | CFG_W | Configuration word 1, latched when an enable is accepted |
| pwr_state | input | 1 | PLL power-state status |
| pll_lock | input | 1 | PLL lock status |
| cfg_rdata | input | CFG_W | Read-back data, valid while `cfg_rd` is high |
| qry | input | 1 | State query pulse |
| pwr_req | output | 1 | PLL power request |
| pll_en | output | 1 | PLL enable |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read-back strobe |
| cfg_sel | output | 1 | Word select for write and read: 0 is word 0, 1 is word 1 |
| cfg_wdata | output | CFG_W | Configuration write data |
| busy | output | 1 | A sequence is in progress |
| err | output | 4 | Sticky timeout flags: power-up, lock, unlock, power-down |
| qry_valid | output | 1 | Query answer valid |
| qry_on | output | 1 | Query answer: PLL enabled |
| qry_cfg0 | output | CFG_W | Query answer: word 0 |
| qry_cfg1 | output | CFG_W | Query answer: word 1, masked to zero unless in HDMI mode |

## Verification
The bench sweeps the power-status delay and the lock-status delay. The sweep includes a delay of zero and delays past the timeout, and it covers both DP and HDMI words. For every strobe it predicts the exact cycle, so a design that leaves a wait one cycle early or late, or that aborts on a timeout, shows up as a shifted edge. The following are each reported as wrong flag values or wrong query data:
- a design that swaps the error bits, or clears them;
- a design that writes word 1 in DP mode;
- a design that returns stale word 1 in DP mode.

A spurious opposite command is sent in the middle of every sequence. A design that accepts commands while busy therefore changes the timing that is checked.

// File: rtl/dpll_seq_pkg.sv
package dpll_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UP_PWR,
      ST_WR0,
      ST_RD0,
      ST_WR1,
      ST_RD1,
      ST_UP_LOCK,
      ST_DN_LOCK,
      ST_DN_PWR
   } seq_state_e;

   localparam int ERR_PWRUP  = 0;
   localparam int ERR_LOCK   = 1;
   localparam int ERR_UNLOCK = 2;
   localparam int ERR_PWRDN  = 3;
   localparam int ERR_N      = 4;

endpackage

// File: rtl/dpll_wait_timer.sv
module dpll_wait_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr || !run) cnt <= '0;
      else if (!expired)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dpll_err_flags.sv
module dpll_err_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)      q <= 1'b0;
         else if (set[i]) q <= 1'b1;
      end
      assign flags[i] = q;
   end
endmodule

// File: rtl/dpll_cfg_query.sv
module dpll_cfg_query #(
   parameter int CFG_W    = 32,
   parameter int HDMI_BIT = 0,
   parameter bit QRY_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap0_en,
   input  logic             cap1_en,
   input  logic [CFG_W-1:0] rdata,
   input  logic             pll_on,
   input  logic             qry,
   output logic             qry_valid,
   output logic             qry_on,
   output logic [CFG_W-1:0] qry_cfg0,
   output logic [CFG_W-1:0] qry_cfg1
);
   logic [CFG_W-1:0] word0_q, word1_q;
   logic [CFG_W-1:0] ans0, ans1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word0_q <= '0;
         word1_q <= '0;
      end else begin
         if (cap0_en) word0_q <= rdata;
         if (cap1_en) word1_q <= rdata;
      end
   end

   always_comb begin
      ans0 = pll_on ? word0_q : '0;
      ans1 = (pll_on && word0_q[HDMI_BIT]) ? word1_q : '0;
   end

   if (QRY_REG) begin : g_qry_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            qry_valid <= 1'b0;
            qry_on    <= 1'b0;
            qry_cfg0  <= '0;
            qry_cfg1  <= '0;
         end else begin
            qry_valid <= qry;
            qry_on    <= qry && pll_on;
            qry_cfg0  <= qry ? ans0 : '0;
            qry_cfg1  <= qry ? ans1 : '0;
         end
      end
   end else begin : g_qry_comb
      assign qry_valid = qry;
      assign qry_on    = qry && pll_on;
      assign qry_cfg0  = qry ? ans0 : '0;
      assign qry_cfg1  = qry ? ans1 : '0;
   end
endmodule

// File: rtl/dpll_seq.sv
module dpll_seq
   import dpll_seq_pkg::*;
#(
   parameter int          CFG_W    = 32,
   parameter int          HDMI_BIT = 0,
   parameter int unsigned CLK_KHZ  = 200000,
   parameter int unsigned TMO_US   = 5000,
   parameter bit          QRY_REG  = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cmd_en,
   input  logic                                cmd_dis,
   input  logic [CFG_W-1:0]                    cfg_word0_in,
   input  logic [CFG_W-1:0]                    cfg_word1_in,
   input  logic                                pwr_state,
   input  logic                                pll_lock,
   input  logic [CFG_W-1:0]                    cfg_rdata,
   input  logic                                qry,
   output logic                                pwr_req,
   output logic                                pll_en,
   output logic                                cfg_wr,
   output logic                                cfg_rd,
   output logic                                cfg_sel,
   output logic [CFG_W-1:0]                    cfg_wdata,
   output logic                                busy,
   output logic [dpll_seq_pkg::ERR_N-1:0]      err,
   output logic                                qry_valid,
   output logic                                qry_on,
   output logic [CFG_W-1:0]                    qry_cfg0,
   output logic [CFG_W-1:0]                    qry_cfg1
);
   localparam int unsigned TMO_CYC = CLK_KHZ * TMO_US / 1000;

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("dpll_seq: timeout must be at least two cycles");
   end
   if (HDMI_BIT >= CFG_W) begin : g_bad_hdmi
      $error("dpll_seq: HDMI_BIT outside the configuration word");
   end

   seq_state_e       st_q, st_d;
   logic [CFG_W-1:0] cfg0_q, cfg1_q;
   logic             latch, pwr_set, pwr_clr, en_set, en_clr;
   logic             cap0_en, cap1_en;
   logic [ERR_N-1:0] err_set;
   logic             in_wait, tmo;

   assign in_wait = (st_q == ST_UP_PWR) || (st_q == ST_UP_LOCK) ||
                    (st_q == ST_DN_LOCK) || (st_q == ST_DN_PWR);

   dpll_wait_timer #(.LIMIT(TMO_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st_d != st_q),
      .run     (in_wait),
      .expired (tmo)
   );

   always_comb begin
      st_d    = st_q;
      latch   = 1'b0;
      pwr_set = 1'b0;
      pwr_clr = 1'b0;
      en_set  = 1'b0;
      en_clr  = 1'b0;
      cap0_en = 1'b0;
      cap1_en = 1'b0;
      err_set = '0;
      case (st_q)
         ST_IDLE: begin
            if (cmd_en) begin
               st_d    = ST_UP_PWR;
               pwr_set = 1'b1;
               latch   = 1'b1;
            end else if (cmd_dis) begin
               st_d   = ST_DN_LOCK;
               en_clr = 1'b1;
            end
         end
         ST_UP_PWR: begin
            if (pwr_state || tmo) begin
               st_d               = ST_WR0;
               err_set[ERR_PWRUP] = !pwr_state;
            end
         end
         ST_WR0: st_d = ST_RD0;
         ST_RD0: begin
            cap0_en = 1'b1;
            if (cfg0_q[HDMI_BIT]) begin
               st_d = ST_WR1;
            end else begin
               st_d   = ST_UP_LOCK;
               en_set = 1'b1;
            end
         end
         ST_WR1: st_d = ST_RD1;
         ST_RD1: begin
            cap1_en = 1'b1;
            st_d    = ST_UP_LOCK;
            en_set  = 1'b1;
         end
         ST_UP_LOCK: begin
            if (pll_lock || tmo) begin
               st_d              = ST_IDLE;
               err_set[ERR_LOCK] = !pll_lock;
            end
         end
         ST_DN_LOCK: begin
            if (!pll_lock || tmo) begin
               st_d                = ST_DN_PWR;
               pwr_clr             = 1'b1;
               err_set[ERR_UNLOCK] = pll_lock;
            end
         end
         ST_DN_PWR: begin
            if (!pwr_state || tmo) begin
               st_d               = ST_IDLE;
               err_set[ERR_PWRDN] = pwr_state;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pwr_req <= 1'b0;
         pll_en  <= 1'b0;
         cfg0_q  <= '0;
         cfg1_q  <= '0;
      end else begin
         st_q <= st_d;
         if (pwr_set)      pwr_req <= 1'b1;
         else if (pwr_clr) pwr_req <= 1'b0;
         if (en_set)       pll_en  <= 1'b1;
         else if (en_clr)  pll_en  <= 1'b0;
         if (latch) begin
            cfg0_q <= cfg_word0_in;
            cfg1_q <= cfg_word1_in;
         end
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign cfg_wr    = (st_q == ST_WR0) || (st_q == ST_WR1);
   assign cfg_rd    = (st_q == ST_RD0) || (st_q == ST_RD1);
   assign cfg_sel   = (st_q == ST_WR1) || (st_q == ST_RD1);
   assign cfg_wdata = cfg_sel ? cfg1_q : cfg0_q;

   dpll_err_flags #(.N(ERR_N)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .flags (err)
   );

   dpll_cfg_query #(
      .CFG_W    (CFG_W),
      .HDMI_BIT (HDMI_BIT),
      .QRY_REG  (QRY_REG)
   ) u_qry (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap0_en   (cap0_en),
      .cap1_en   (cap1_en),
      .rdata     (cfg_rdata),
      .pll_on    (pll_en),
      .qry       (qry),
      .qry_valid (qry_valid),
      .qry_on    (qry_on),
      .qry_cfg0  (qry_cfg0),
      .qry_cfg1  (qry_cfg1)
   );
endmodule

// File: rtl/dpll_seq_chk.sv
module dpll_seq_chk #(
   parameter int CFG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_req,
   input logic             pll_en,
   input logic             cfg_wr,
   input logic             cfg_rd,
   input logic             cfg_sel,
   input logic             busy,
   input logic [3:0]       err,
   input logic             hdmi_lat,
   input logic             qry_valid,
   input logic             qry_on,
   input logic [CFG_W-1:0] qry_cfg0,
   input logic [CFG_W-1:0] qry_cfg1
);
   AST_EN_UNDER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> pwr_req); // R1

   AST_CFG1_HDMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel) |-> hdmi_lat); // R2

   AST_RD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_rd && (cfg_sel == $past(cfg_sel)))); // R3

   AST_PWR_DROP_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_req) |-> !pll_en); // R4

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err & $past(err)) == $past(err))); // R6

   AST_QRY_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && !qry_on) |-> (qry_cfg0 == '0 && qry_cfg1 == '0)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(cfg_wr || cfg_rd)); // R8
endmodule

bind dpll_seq dpll_seq_chk #(.CFG_W(CFG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_req   (pwr_req),
   .pll_en    (pll_en),
   .cfg_wr    (cfg_wr),
   .cfg_rd    (cfg_rd),
   .cfg_sel   (cfg_sel),
   .busy      (busy),
   .err       (err),
   .hdmi_lat  (cfg0_q[HDMI_BIT]),
   .qry_valid (qry_valid),
   .qry_on    (qry_on),
   .qry_cfg0  (qry_cfg0),
   .qry_cfg1  (qry_cfg1)
);

// File: tb/dpll_seq_tb.sv
module dpll_seq_tb;
   localparam int CW = 32;
   localparam int T  = 20;   // 1000 kHz * 20 us

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_en = 1'b0, cmd_dis = 1'b0, qry = 1'b0;
   logic [CW-1:0] cfg_word0_in = '0, cfg_word1_in = '0;
   logic          pwr_state, pll_lock;
   logic [CW-1:0] cfg_rdata;
   logic          pwr_req, pll_en, cfg_wr, cfg_rd, cfg_sel, busy;
   logic [CW-1:0] cfg_wdata, qry_cfg0, qry_cfg1;
   logic [3:0]    err;
   logic          qry_valid, qry_on;

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;
   logic [7:0] pd = 8'd0, ld = 8'd0, pcnt, lcnt;
   logic [CW-1:0] mem0, mem1;

   always #2.5 clk = ~clk;

   dpll_seq #(.CFG_W(CW), .HDMI_BIT(0), .CLK_KHZ(1000), .TMO_US(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
      .cfg_word0_in(cfg_word0_in), .cfg_word1_in(cfg_word1_in),
      .pwr_state(pwr_state), .pll_lock(pll_lock), .cfg_rdata(cfg_rdata),
      .qry(qry), .pwr_req(pwr_req), .pll_en(pll_en), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .busy(busy),
      .err(err), .qry_valid(qry_valid), .qry_on(qry_on),
      .qry_cfg0(qry_cfg0), .qry_cfg1(qry_cfg1));

   always @(posedge clk) cyc <= cyc + 1;

   // status models: follow the request after a programmable delay
   always @(posedge clk) begin
      if (!rst_n) begin
         pwr_state <= 1'b0; pcnt <= '0;
         pll_lock  <= 1'b0; lcnt <= '0;
      end else begin
         if (pwr_req != pwr_state) begin
            if (pcnt >= pd) begin pwr_state <= pwr_req; pcnt <= '0; end
            else pcnt <= pcnt + 1'b1;
         end else pcnt <= '0;
         if (pll_en != pll_lock) begin
            if (lcnt >= ld) begin pll_lock <= pll_en; lcnt <= '0; end
            else lcnt <= lcnt + 1'b1;
         end else lcnt <= '0;
      end
   end

   // configuration register model
   always @(posedge clk) begin
      if (!rst_n) begin
         mem0 <= '0; mem1 <= 32'hDEAD_BEEF;
      end else if (cfg_wr) begin
         if (cfg_sel) mem1 <= cfg_wdata;
         else         mem0 <= cfg_wdata;
      end
   end
   assign cfg_rdata = cfg_sel ? mem1 : mem0;

   task automatic chk(input string req, input string what,
                      input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int wt(input int d);
      return (d + 2 > T) ? T : d + 2;
   endfunction

   // run one sequence, record relative times of events
   task automatic run_seq(input bit is_en, input logic [CW-1:0] c0, input logic [CW-1:0] c1,
                          output int t_pwr, output int t_wr0, output int t_wr1,
                          output int n_wr1, output int t_en, output int t_done,
                          output logic [CW-1:0] wd0, output logic [CW-1:0] wd1);
      int base;
      t_pwr = -1; t_wr0 = -1; t_wr1 = -1; n_wr1 = 0; t_en = -1; t_done = -1;
      wd0 = '0; wd1 = '0;
      @(negedge clk);
      cfg_word0_in = c0; cfg_word1_in = c1;
      if (is_en) cmd_en = 1'b1; else cmd_dis = 1'b1;
      base = cyc + 1;
      @(negedge clk);
      cmd_en = 1'b0; cmd_dis = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (t_pwr < 0 && pwr_req == is_en) t_pwr = cyc - base;
         if (t_en < 0 && pll_en == is_en) t_en = cyc - base;
         if (cfg_wr && !cfg_sel && t_wr0 < 0) begin t_wr0 = cyc - base; wd0 = cfg_wdata; end
         if (cfg_wr && cfg_sel) begin n_wr1++; t_wr1 = cyc - base; wd1 = cfg_wdata; end
         if (!busy) begin t_done = cyc - base; break; end
         // spurious opposite command while busy (R8)
         if (k == 2) begin if (is_en) cmd_dis = 1'b1; else cmd_en = 1'b1; end
         else begin cmd_en = 1'b0; cmd_dis = 1'b0; end
         @(negedge clk);
      end
      cmd_en = 1'b0; cmd_dis = 1'b0;
   endtask

   task automatic do_query(input logic exp_on, input logic [CW-1:0] e0,
                           input logic [CW-1:0] e1);
      @(negedge clk);
      qry = 1'b1;
      @(negedge clk);
      qry = 1'b0;
      chk("R7", "qry_valid", CW'(qry_valid), CW'(1'b1));
      chk("R7", "qry_on", CW'(qry_on), CW'(exp_on));
      chk("R7", "qry_cfg0", qry_cfg0, e0);
      chk("R7", "qry_cfg1", qry_cfg1, e1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int pd_l[5] = '{0, 1, 3, 7, 25};
      int ld_l[3] = '{0, 2, 25};
      int tp, tw0, tw1, nw1, te, td, a, e;
      logic [CW-1:0] wd0, wd1, c0, c1;
      bit pto, lto;

      do_reset();
      // R9 reset state
      chk("R9", "reset outputs",
          CW'({pwr_req, pll_en, busy, cfg_wr, cfg_rd, qry_valid}), '0);
      chk("R9", "reset err", CW'(err), '0);

      for (int ip = 0; ip < 5; ip++) begin
         for (int il = 0; il < 3; il++) begin
            for (int h = 0; h < 2; h++) begin
               pd = 8'(pd_l[ip]); ld = 8'(ld_l[il]);
               do_reset();
               c0 = 32'h1234_5670 + CW'((ip * 6 + il * 2) << 4) + CW'(h);
               c1 = 32'hA5A5_0000 + CW'(ip * 16 + il);
               pto = (pd_l[ip] + 2 > T);
               lto = (ld_l[il] + 2 > T);
               a = wt(pd_l[ip]);
               e = a + 2 + (h ? 2 : 0);

               run_seq(1'b1, c0, c1, tp, tw0, tw1, nw1, te, td, wd0, wd1);
               chk("R1", "pwr_req rise", CW'(tp), CW'(0));
               chk("R5", "word0 write cycle", CW'(tw0), CW'(a));
               chk("R1", "word0 data", wd0, c0);
               chk("R2", "word1 write count", CW'(nw1), CW'(h));
               if (h) begin
                  chk("R3", "word1 write cycle", CW'(tw1), CW'(a + 2));
                  chk("R2", "word1 data", wd1, c1);
               end
               chk("R1", "pll_en rise", CW'(te), CW'(e));
               chk("R1", "busy end after lock", CW'(td), CW'(e + wt(ld_l[il])));
               chk("R5", "err after enable", CW'(err), CW'({2'b00, lto, pto}));
               repeat (40) @(negedge clk);
               do_query(1'b1, c0, h ? c1 : '0);

               run_seq(1'b0, c0, c1, tp, tw0, tw1, nw1, te, td, wd0, wd1);
               chk("R4", "pll_en fall", CW'(te), CW'(0));
               chk("R4", "pwr_req fall", CW'(tp), CW'(wt(ld_l[il])));
               chk("R4", "busy end after power off", CW'(td),
                   CW'(wt(ld_l[il]) + wt(pd_l[ip])));
               chk("R6", "err after disable", CW'(err), CW'({pto, lto, lto, pto}));
               repeat (40) @(negedge clk);
               do_query(1'b0, '0, '0);
               chk("R6", "err held", CW'(err), CW'({pto, lto, lto, pto}));
            end
         end
      end

      // R8 enable wins over a simultaneous disable
      pd = 8'd0; ld = 8'd0;
      do_reset();
      @(negedge clk);
      cmd_en = 1'b1; cmd_dis = 1'b1; cfg_word0_in = 32'h0000_0010;
      @(negedge clk);
      cmd_en = 1'b0; cmd_dis = 1'b0;
      chk("R8", "enable precedence pwr_req", CW'(pwr_req), CW'(1'b1));
      chk("R8", "busy after accept", CW'(busy), CW'(1'b1));
      repeat (30) @(negedge clk);
      chk("R8", "busy cleared", CW'(busy), CW'(1'b0));
      chk("R1", "enabled at end", CW'(pll_en), CW'(1'b1));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule